// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block sits after the clock synthesizer and in front of the output drivers. It decides which derived clocks run and which are parked. Four source clocks enter the block: a processor-class clock, a peripheral bus clock, an interrupt-controller reference clock and a memory-buffer clock. Each source leaves the block as one free-running copy and a parameterised number of gated copies. Two asynchronous active-low stop requests control the gating. The host stop request parks the gated processor, interrupt-controller and memory groups. The bus stop request parks only the gated bus group.

The model runs on a fast system clock that oversamples the source clocks, which arrive as slow toggling digital signals. For each group, the stop request is synchronized on the rising edges of that group's own free-running source. The run/stop state may change only while the source is low. A gated copy therefore always stops after a complete high phase and restarts with a complete high phase, so no shortened pulse appears at an output. Each group has a stopped flag that reports when its gated copies are parked low.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every clock output is 0 and every stopped flag is 0.
- R2: Each free-running output equals its source sampled one system-clock cycle earlier. Neither stop input has any effect on it.
- R3: While the processor group runs, each gated processor output equals the free-running processor output. Once the group is stopped, all its gated outputs stay 0. A group that is stopped while its source is high stays stopped through that whole high phase.
- R4: The stop request is sampled on rising edges of the group's own source through a synchronizer of 2 stages. After the host stop input falls, the gated processor output shows 1 or 2 further rising edges, and then the stopped flag rises within 15 system cycles of the fall. After the host stop input rises again, the free-running processor output shows 1 or 2 rising edges before the gated output restarts. The restart happens in the same cycle as a rising edge of the free-running output.
- R5: The bus stop input gates only the bus group, and the host stop input never gates the bus group. The gated bus outputs follow the free-running bus output while running and stay 0 while stopped.
- R6: The host stop input also gates the interrupt-controller and memory-buffer groups, with the same sampling rule as the processor group. The bus stop input has no effect on these groups.
- R7: Each group's stopped flag (1 = parked) changes only in a cycle that follows a cycle in which that group's source was low.
- R8: A gated output rises only in a cycle in which its free-running companion rises, and falls only in a cycle in which its companion falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples the sources |
| rst | input | 1 | Synchronous active-high reset |
| host_stop_n | input | 1 | Asynchronous active-low stop for processor, interrupt-controller and memory groups |
| bus_stop_n | input | 1 | Asynchronous active-low stop for the bus group |
| cpu_src | input | 1 | Processor-class source clock |
| bus_src | input | 1 | Bus source clock |
| apic_src | input | 1 | Interrupt-controller reference source clock |
| mem_src | input | 1 | Memory-buffer source clock |
| cpu_free | output | 1 | Free-running processor copy |
| cpu_gated | output | N_CPU (2) | Gated processor copies |
| bus_free | output | 1 | Free-running bus copy |
| bus_gated | output | N_BUS (6) | Gated bus copies |
| apic_free | output | 1 | Free-running interrupt-controller copy |
| apic_gated | output | N_APIC (1) | Gated interrupt-controller copies |
| mem_free | output | 1 | Free-running memory-buffer copy |
| mem_gated | output | N_MEM (16) | Gated memory-buffer copies |
| cpu_stopped | output | 1 | Processor group parked |
| bus_stopped | output | 1 | Bus group parked |
| apic_stopped | output | 1 | Interrupt-controller group parked |
| mem_stopped | output | 1 | Memory-buffer group parked |

## Verification
Suppose the run state of a group is wrong, for example updated during a high phase. The damage shows at once as a gated copy that differs from its free-running companion for part of a high phase, and the per-cycle comparison sees it in that same system cycle. A synchronizer that is too short or too long shifts the parking point by a whole source period. This changes the count of gated rising edges after the request, so it is caught within about three source periods. A stop input routed to the wrong group shows as a parked copy in a group that should run, and this appears within the same window.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;

    // Present and previous sampled level of one source clock
    typedef struct packed {
        logic cur;
        logic prev;
    } src_hist_t;

    function automatic edge_e classify_edge(input src_hist_t h);
        if (h.cur && !h.prev)
            return EDGE_RISE;
        else if (!h.cur && h.prev)
            return EDGE_FALL;
        else
            return EDGE_NONE;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '1;
                else if (sample_en)
                    chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '1;
                else if (sample_en)
                    chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    // R4: the synchronized request moves only on a source rising edge
    p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(q));

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src,
    input  logic             stop_n,
    output logic             free_o,
    output logic [WIDTH-1:0] gated_o,
    output logic             stopped_o
);
    src_hist_t hist;
    edge_e     src_edge;
    logic      stop_sync_n;
    logic      run_en;
    logic      rise_seen;

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else
            hist <= '{cur: src, prev: hist.cur};
    end

    assign src_edge  = classify_edge(hist);
    assign rise_seen = (src_edge == EDGE_RISE);

    clkstop_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sample_en (rise_seen),
        .d         (stop_n),
        .q         (stop_sync_n)
    );

    // Run state is only re-decided while the source sits low
    always_ff @(posedge clk) begin
        if (rst)
            run_en <= 1'b1;
        else if (!hist.cur)
            run_en <= stop_sync_n;
    end

    assign free_o    = hist.cur;
    assign stopped_o = ~run_en;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_fan
            assign gated_o[i] = hist.cur & run_en;
        end
    endgenerate

    // R7: run state flips only after a low source sample
    p_change_in_low_r7: assert property (@(posedge clk) disable iff (rst)
        (run_en != $past(run_en)) |-> !$past(hist.cur));

    // R3: a group parked during a high phase remains parked through it
    p_parked_through_high_r3: assert property (@(posedge clk) disable iff (rst)
        (stopped_o && hist.cur && src) |=> stopped_o);

    // R8: gated copy starts only together with its companion
    p_whole_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(gated_o[0]) |-> $rose(free_o));

    // R8: gated copy ends only together with its companion
    p_whole_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(gated_o[0]) |-> $fell(free_o));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU       = 2,
    parameter int unsigned N_BUS       = 6,
    parameter int unsigned N_APIC      = 1,
    parameter int unsigned N_MEM       = 16,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_stop_n,
    input  logic              bus_stop_n,
    input  logic              cpu_src,
    input  logic              bus_src,
    input  logic              apic_src,
    input  logic              mem_src,
    output logic              cpu_free,
    output logic [N_CPU-1:0]  cpu_gated,
    output logic              bus_free,
    output logic [N_BUS-1:0]  bus_gated,
    output logic              apic_free,
    output logic [N_APIC-1:0] apic_gated,
    output logic              mem_free,
    output logic [N_MEM-1:0]  mem_gated,
    output logic              cpu_stopped,
    output logic              bus_stopped,
    output logic              apic_stopped,
    output logic              mem_stopped
);
    clkstop_gate #(.WIDTH(N_CPU), .STAGES(SYNC_STAGES)) u_cpu (
        .clk(clk), .rst(rst), .src(cpu_src), .stop_n(host_stop_n),
        .free_o(cpu_free), .gated_o(cpu_gated), .stopped_o(cpu_stopped)
    );

    clkstop_gate #(.WIDTH(N_BUS), .STAGES(SYNC_STAGES)) u_bus (
        .clk(clk), .rst(rst), .src(bus_src), .stop_n(bus_stop_n),
        .free_o(bus_free), .gated_o(bus_gated), .stopped_o(bus_stopped)
    );

    clkstop_gate #(.WIDTH(N_APIC), .STAGES(SYNC_STAGES)) u_apic (
        .clk(clk), .rst(rst), .src(apic_src), .stop_n(host_stop_n),
        .free_o(apic_free), .gated_o(apic_gated), .stopped_o(apic_stopped)
    );

    clkstop_gate #(.WIDTH(N_MEM), .STAGES(SYNC_STAGES)) u_mem (
        .clk(clk), .rst(rst), .src(mem_src), .stop_n(host_stop_n),
        .free_o(mem_free), .gated_o(mem_gated), .stopped_o(mem_stopped)
    );

    // R1: the cycle after a reset cycle shows quiet outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!cpu_free && !bus_free && !apic_free && !mem_free &&
                 !cpu_stopped && !bus_stopped && !apic_stopped && !mem_stopped));

endmodule

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_CPU  = 2;
    localparam int N_BUS  = 6;
    localparam int N_APIC = 1;
    localparam int N_MEM  = 16;
    localparam int SYNC   = 2;
    localparam int LAST   = 520;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_stop_n = 1'b1, bus_stop_n = 1'b1;
    logic cpu_src = 1'b0, bus_src = 1'b0, apic_src = 1'b0, mem_src = 1'b0;
    logic cpu_free, bus_free, apic_free, mem_free;
    logic [N_CPU-1:0]  cpu_gated;
    logic [N_BUS-1:0]  bus_gated;
    logic [N_APIC-1:0] apic_gated;
    logic [N_MEM-1:0]  mem_gated;
    logic cpu_stopped, bus_stopped, apic_stopped, mem_stopped;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkstop_ctrl #(.N_CPU(N_CPU), .N_BUS(N_BUS), .N_APIC(N_APIC), .N_MEM(N_MEM),
                   .SYNC_STAGES(SYNC)) i_clkstop_ctrl (
        .clk(clk), .rst(rst), .host_stop_n(host_stop_n), .bus_stop_n(bus_stop_n),
        .cpu_src(cpu_src), .bus_src(bus_src), .apic_src(apic_src), .mem_src(mem_src),
        .cpu_free(cpu_free), .cpu_gated(cpu_gated), .bus_free(bus_free),
        .bus_gated(bus_gated), .apic_free(apic_free), .apic_gated(apic_gated),
        .mem_free(mem_free), .mem_gated(mem_gated), .cpu_stopped(cpu_stopped),
        .bus_stopped(bus_stopped), .apic_stopped(apic_stopped), .mem_stopped(mem_stopped)
    );

    // Behavioural reference: group 0 cpu, 1 bus, 2 apic, 3 mem
    logic       m_cur [4];
    logic       m_prev[4];
    logic [7:0] m_hist[4];
    logic       m_en  [4];

    function automatic logic src_of(input int g);
        case (g)
            0: return cpu_src;
            1: return bus_src;
            2: return apic_src;
            default: return mem_src;
        endcase
    endfunction

    function automatic logic stop_of(input int g);
        return (g == 1) ? bus_stop_n : host_stop_n;
    endfunction

    always @(posedge clk) begin
        for (int g = 0; g < 4; g++) begin
            logic nen;
            if (rst) begin
                m_cur[g] = 1'b0; m_prev[g] = 1'b0; m_hist[g] = '1; m_en[g] = 1'b1;
            end else begin
                nen = m_cur[g] ? m_en[g] : m_hist[g][SYNC-1];
                if (m_cur[g] && !m_prev[g])
                    m_hist[g] = {m_hist[g][6:0], stop_of(g)};
                m_prev[g] = m_cur[g];
                m_cur[g]  = src_of(g);
                m_en[g]   = nen;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rep(input logic b, input int w);
        return b ? ((32'h1 << w) - 32'h1) : 32'h0;
    endfunction

    task automatic compare_all(input bit in_reset);
        string rf, rg0, rg1, rg2, rs;
        rf  = in_reset ? "R1" : "R2";
        rg0 = in_reset ? "R1" : "R3";
        rg1 = in_reset ? "R1" : "R5";
        rg2 = in_reset ? "R1" : "R6";
        rs  = in_reset ? "R1" : "R7";
        chk(rf,  "cpu_free",  {31'd0, cpu_free},  {31'd0, m_cur[0]});
        chk(rf,  "bus_free",  {31'd0, bus_free},  {31'd0, m_cur[1]});
        chk(rf,  "apic_free", {31'd0, apic_free}, {31'd0, m_cur[2]});
        chk(rf,  "mem_free",  {31'd0, mem_free},  {31'd0, m_cur[3]});
        chk(rg0, "cpu_gated", 32'(cpu_gated),  rep(m_cur[0] & m_en[0], N_CPU));
        chk(rg1, "bus_gated", 32'(bus_gated),  rep(m_cur[1] & m_en[1], N_BUS));
        chk(rg2, "apic_gated", 32'(apic_gated), rep(m_cur[2] & m_en[2], N_APIC));
        chk(rg2, "mem_gated", 32'(mem_gated),  rep(m_cur[3] & m_en[3], N_MEM));
        chk(rs,  "cpu_stopped",  {31'd0, cpu_stopped},  {31'd0, ~m_en[0]});
        chk(rs,  "bus_stopped",  {31'd0, bus_stopped},  {31'd0, ~m_en[1]});
        chk(rs,  "apic_stopped", {31'd0, apic_stopped}, {31'd0, ~m_en[2]});
        chk(rs,  "mem_stopped",  {31'd0, mem_stopped},  {31'd0, ~m_en[3]});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic pg_cpu, pf_cpu, pg_bus, pf_bus;
        int mode, cnt, t0;
        pg_cpu = 0; pf_cpu = 0; pg_bus = 0; pf_bus = 0;
        mode = 0; cnt = 0; t0 = 0;
        for (int cyc = 0; cyc <= LAST; cyc++) begin
            @(negedge clk);
            compare_all(rst);

            // R8: edges of gated copies coincide with companion edges
            if (!rst && cpu_gated[0] !== pg_cpu)
                chk("R8", "cpu_free edge with gated edge",
                    {30'd0, pf_cpu, cpu_free}, {30'd0, pg_cpu, cpu_gated[0]});
            if (!rst && bus_gated[0] !== pg_bus)
                chk("R8", "bus_free edge with gated edge",
                    {30'd0, pf_bus, bus_free}, {30'd0, pg_bus, bus_gated[0]});

            // R4: latency measurement on the processor group
            if (mode == 1) begin
                if (cpu_gated[0] && !pg_cpu) cnt++;
                if (cpu_stopped) begin
                    chk("R4", "gated rises after stop request in 1..2",
                        32'(cnt >= 1 && cnt <= 2), 32'd1);
                    chk("R4", "stop flag within 15 cycles",
                        32'(cyc - t0 <= 15), 32'd1);
                    mode = 0;
                end
            end else if (mode == 2) begin
                if (cpu_gated[0] && !pg_cpu) begin
                    chk("R4", "free rises before restart in 1..2",
                        32'(cnt >= 1 && cnt <= 2), 32'd1);
                    chk("R4", "restart on free rising edge",
                        {31'd0, cpu_free && !pf_cpu}, 32'd1);
                    mode = 0;
                end else if (cpu_free && !pf_cpu) begin
                    cnt++;
                end
            end

            pg_cpu = cpu_gated[0]; pf_cpu = cpu_free;
            pg_bus = bus_gated[0]; pf_bus = bus_free;

            // Drive the next input values
            rst         = (cyc < 4);
            cpu_src     = ((cyc / 2) % 2) == 1;
            bus_src     = ((cyc / 4) % 2) == 1;
            apic_src    = ((cyc / 5) % 2) == 1;
            mem_src     = ((cyc / 3) % 2) == 1;
            host_stop_n = !((cyc >= 100 && cyc < 200) || (cyc >= 300 && cyc < 340) ||
                            (cyc == 400));
            bus_stop_n  = !((cyc >= 150 && cyc < 260) || (cyc >= 300 && cyc < 360));
            if (cyc == 100) begin mode = 1; cnt = 0; t0 = cyc; end
            if (cyc == 200) begin mode = 2; cnt = 0; t0 = cyc; end
        end
        chk("R4", "latency windows closed", 32'(mode), 32'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule